// File: doc/BRIEF.md
# Per-Queue Barrier Dispatch Gate

The gate sits between a set of command queues and one kernel dispatcher. Each queue keeps a count of packets waiting to be taken, and presents the header of its oldest packet on a flat header bus. When a queue has work and nothing holds it back, the gate books a processing pass for it. That pass becomes eligible a fixed number of cycles later. Eligible queues are served in round-robin order, one packet per cycle. The gate reads the type field of the header to decide where the packet goes. Kernel packets go to the dispatcher over a valid/ready handshake. All other packets, barrier-AND packets among them, leave on a side strobe that takes one cycle.

In-order execution of kernels is enforced by a sticky hold flag kept for each queue. When a kernel packet whose header has the barrier bit set is accepted by the dispatcher, the flag of its queue is raised. While the flag is up, that queue cannot book a new pass, and other queues keep running. A completion strobe carries a queue index. It clears that queue's flag. If packets are still waiting, the cleared flag lets a new pass be booked. If the queue has an outstanding kernel, the completion also frees its slot, which is shown as a read-index advance strobe.

Top module: `barrier_dispatch_gate`

## Requirements
- R1: After reset, disp_valid, side_valid and free_valid are low and every bit of barrier_held is clear.
- R2: A head packet whose header bits [7:0] equal 2 (kernel) is offered on the dispatcher port, with disp_qid giving its queue and disp_hdr giving its header.
- R3: A head packet with any other value in bits [7:0] (for example 3, barrier-AND, or 0) is presented for one cycle on side_valid/side_qid and never raises barrier_held.
- R4: A kernel accepted with header bit 8 set raises its queue's barrier_held bit in the cycle after the handshake. A kernel accepted with bit 8 clear leaves the bit clear.
- R5: While a queue's barrier_held bit is set, that queue is never offered on the dispatcher port, even with packets waiting, and other queues are still served.
- R6: A completion for a queue whose barrier_held bit is set clears the bit. Waiting packets for that queue are then offered again. With none waiting, nothing is offered.
- R7: A completion for a queue whose barrier_held bit is clear leaves the bit clear.
- R8: free_valid is high, with free_qid equal to cmpl_qid, in the cycle of a completion exactly when that queue has at least one accepted kernel not yet completed.
- R9: With DELAY=2, a packet pushed into an idle queue is first offered DELAY+1 clock edges after the push edge: one edge to book the pass and DELAY edges of wait.
- R10: Eligible queues are served in round-robin order, starting from the queue after the last one served, with at most one packet taken per cycle.
- R11: While disp_valid is high and disp_ready is low, disp_valid stays high and disp_qid does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Adds one waiting packet to a queue |
| push_qid | input | QW | Queue that receives the push |
| head_hdr | input | NQ*HDR_W | Header of the oldest packet of each queue, queue 0 in the low bits |
| disp_valid | output | 1 | Kernel packet offered to the dispatcher |
| disp_ready | input | 1 | Dispatcher accepts the offered packet |
| disp_qid | output | QW | Queue of the offered kernel |
| disp_hdr | output | HDR_W | Header of the offered kernel |
| side_valid | output | 1 | A non-kernel packet is taken this cycle |
| side_qid | output | QW | Queue of the non-kernel packet |
| cmpl_valid | input | 1 | Kernel completion strobe |
| cmpl_qid | input | QW | Queue of the completed kernel |
| free_valid | output | 1 | Slot freed; the read index of free_qid advances |
| free_qid | output | QW | Queue whose slot is freed |
| barrier_held | output | NQ | Hold flag of each queue |

## Verification
The hardest situation to reach is a held queue that has packets waiting while a neighbouring queue is being served. In that state the gate has to keep refusing the held queue across many cycles, and still resume it after the completion. The bench builds this by dispatching a kernel with bit 8 set, then pushing more work into the same queue and into a second queue. It watches the dispatcher port for a window well longer than the pass delay, and only then sends the completion. A sweep over every queue, both values of the barrier bit and three type codes covers the routing and the flag updates. A second completion with no work waiting shows that the queue stays quiet.

// File: rtl/barrier_dispatch_gate.sv
module barrier_dispatch_gate #(
  parameter int NQ          = 4,
  parameter int HDR_W       = 16,
  parameter int TYPE_POS    = 0,
  parameter int TYPE_W      = 8,
  parameter int BAR_POS     = 8,
  parameter int KERNEL_TYPE = 2,
  parameter int DELAY       = 2,
  parameter int CNT_W       = 4,
  localparam int QW         = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int TW         = $clog2(DELAY + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_valid,
  input  logic [QW-1:0]       push_qid,
  input  logic [NQ*HDR_W-1:0] head_hdr,
  output logic                disp_valid,
  input  logic                disp_ready,
  output logic [QW-1:0]       disp_qid,
  output logic [HDR_W-1:0]    disp_hdr,
  output logic                side_valid,
  output logic [QW-1:0]       side_qid,
  input  logic                cmpl_valid,
  input  logic [QW-1:0]       cmpl_qid,
  output logic                free_valid,
  output logic [QW-1:0]       free_qid,
  output logic [NQ-1:0]       barrier_held
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [TYPE_W-1:0] type_of(input logic [HDR_W-1:0] h);
    return TYPE_W'(h >> TYPE_POS);
  endfunction

  function automatic logic bar_of(input logic [HDR_W-1:0] h);
    return 1'((h >> BAR_POS) & HDR_W'(1));
  endfunction

  logic [CNT_W-1:0] pend [NQ];
  logic [CNT_W-1:0] infl [NQ];
  logic [TW-1:0]    tmr  [NQ];
  logic [NQ-1:0]    sched, held, ready;
  logic [QW-1:0]    ptr, pick, lock_q;
  logic             lock, any, is_k, take;
  logic [HDR_W-1:0] cur_hdr;

  always_comb begin
    for (int q = 0; q < NQ; q++) ready[q] = sched[q] && (tmr[q] == '0);
  end

  always_comb begin
    any  = 1'b0;
    pick = ptr;
    for (int i = 0; i < NQ; i++) begin
      int j;
      j = (int'(ptr) + i) % NQ;
      if (!any && ready[j]) begin
        any  = 1'b1;
        pick = QW'(j);
      end
    end
    if (lock) begin
      any  = 1'b1;
      pick = lock_q;
    end
  end

  assign cur_hdr      = head_hdr[pick*HDR_W +: HDR_W];
  assign is_k         = (type_of(cur_hdr) == TYPE_W'(KERNEL_TYPE));
  assign disp_valid   = any && is_k;
  assign side_valid   = any && !is_k;
  assign disp_qid     = pick;
  assign disp_hdr     = cur_hdr;
  assign side_qid     = pick;
  assign take         = side_valid || (disp_valid && disp_ready);
  assign free_valid   = cmpl_valid && (infl[cmpl_qid] != '0);
  assign free_qid     = cmpl_qid;
  assign barrier_held = held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      lock   <= 1'b0;
      lock_q <= '0;
      sched  <= '0;
      held   <= '0;
      for (int q = 0; q < NQ; q++) begin
        pend[q] <= '0;
        infl[q] <= '0;
        tmr[q]  <= '0;
      end
    end else begin
      lock   <= disp_valid && !disp_ready;
      lock_q <= pick;
      if (take) ptr <= (int'(pick) + 1 == NQ) ? '0 : pick + 1'b1;
      for (int q = 0; q < NQ; q++) begin
        logic pop, add, done, fr;
        pop  = take && (int'(pick) == q);
        add  = push_valid && (int'(push_qid) == q) && (pend[q] != CNT_MAX);
        done = cmpl_valid && (int'(cmpl_qid) == q);
        fr   = done && (infl[q] != '0);
        pend[q] <= pend[q] + CNT_W'(add) - CNT_W'(pop);
        infl[q] <= infl[q] + CNT_W'(pop && is_k) - CNT_W'(fr);
        if (pop) begin
          sched[q] <= 1'b0;
        end else if (!sched[q] && !held[q] && pend[q] != '0) begin
          sched[q] <= 1'b1;
          tmr[q]   <= TW'(DELAY);
        end else if (sched[q] && tmr[q] != '0) begin
          tmr[q] <= tmr[q] - 1'b1;
        end
        if (pop && is_k && bar_of(cur_hdr)) held[q] <= 1'b1;
        else if (done)                       held[q] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/barrier_dispatch_gate_chk.sv
module barrier_dispatch_gate_chk #(
  parameter int NQ          = 4,
  parameter int HDR_W       = 16,
  parameter int TYPE_POS    = 0,
  parameter int TYPE_W      = 8,
  parameter int BAR_POS     = 8,
  parameter int KERNEL_TYPE = 2,
  localparam int QW         = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [QW-1:0]    disp_qid,
  input logic [HDR_W-1:0] disp_hdr,
  input logic             side_valid,
  input logic [QW-1:0]    side_qid,
  input logic             cmpl_valid,
  input logic [QW-1:0]    cmpl_qid,
  input logic             free_valid,
  input logic [NQ-1:0]    barrier_held
);

  a_r11_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_qid));

  a_r2_kernel_only: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_hdr[TYPE_POS +: TYPE_W] == TYPE_W'(KERNEL_TYPE));

  a_r5_not_held: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !barrier_held[disp_qid]);

  a_r8_free_needs_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> cmpl_valid);

  for (genvar q = 0; q < NQ; q++) begin : g_q
    a_r4_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(barrier_held[q]) |->
        $past(disp_valid && disp_ready && int'(disp_qid) == q && disp_hdr[BAR_POS]));

    a_r6_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(barrier_held[q]) |-> $past(cmpl_valid && int'(cmpl_qid) == q));

    a_r3_side_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      side_valid && int'(side_qid) == q && !barrier_held[q] |=> !barrier_held[q]);
  end

endmodule

bind barrier_dispatch_gate barrier_dispatch_gate_chk #(
  .NQ(NQ), .HDR_W(HDR_W), .TYPE_POS(TYPE_POS), .TYPE_W(TYPE_W),
  .BAR_POS(BAR_POS), .KERNEL_TYPE(KERNEL_TYPE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_qid(disp_qid), .disp_hdr(disp_hdr), .side_valid(side_valid),
  .side_qid(side_qid), .cmpl_valid(cmpl_valid), .cmpl_qid(cmpl_qid),
  .free_valid(free_valid), .barrier_held(barrier_held)
);

// File: tb/barrier_dispatch_gate_tb.sv
module barrier_dispatch_gate_tb;
  localparam int NQ = 4, HDR_W = 16, QW = 2, DELAY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0, disp_ready = 1'b1, cmpl_valid = 1'b0;
  logic [QW-1:0] push_qid = '0, cmpl_qid = '0;
  logic [HDR_W-1:0] hh [NQ];
  logic [NQ*HDR_W-1:0] head_hdr;
  logic disp_valid, side_valid, free_valid;
  logic [QW-1:0] disp_qid, side_qid, free_qid;
  logic [HDR_W-1:0] disp_hdr;
  logic [NQ-1:0] barrier_held;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  always_comb for (int q = 0; q < NQ; q++) head_hdr[q*HDR_W +: HDR_W] = hh[q];

  barrier_dispatch_gate #(.NQ(NQ), .HDR_W(HDR_W), .DELAY(DELAY)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_qid(push_qid),
    .head_hdr(head_hdr), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_qid(disp_qid), .disp_hdr(disp_hdr), .side_valid(side_valid),
    .side_qid(side_qid), .cmpl_valid(cmpl_valid), .cmpl_qid(cmpl_qid),
    .free_valid(free_valid), .free_qid(free_qid), .barrier_held(barrier_held));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic push(input int q);
    push_valid = 1'b1;
    push_qid   = QW'(q);
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic cmpl(input int q, output logic fr, output int fq);
    cmpl_valid = 1'b1;
    cmpl_qid   = QW'(q);
    #1;
    fr = free_valid;
    fq = int'(free_qid);
    @(posedge clk);
    @(negedge clk);
    cmpl_valid = 1'b0;
  endtask

  task automatic wait_any(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (disp_valid || side_valid) begin
        seen = 1'b1;
        break;
      end
      step();
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic seen, fr, bad, saw2;
    int fq;
    for (int q = 0; q < NQ; q++) hh[q] = 16'h0002;
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!disp_valid && !side_valid && !free_valid, "R1 outputs idle", int'(disp_valid), 0);
    chk(barrier_held == '0, "R1 flags clear", int'(barrier_held), 0);
    step();

    // R9 latency
    push(1);
    for (int n = 0; n < DELAY; n++) begin
      chk(!disp_valid, "R9 not early", int'(disp_valid), 0);
      step();
    end
    chk(!disp_valid, "R9 not early", int'(disp_valid), 0);
    step();
    chk(disp_valid && disp_qid == 2'd1, "R9 offered on time", int'(disp_valid), 1);
    step();
    cmpl(1, fr, fq);

    // R2 R3 R4 R7 R8 sweep
    for (int q = 0; q < NQ; q++)
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < 3; k++) begin
          int t;
          logic ek;
          t  = (k == 0) ? 0 : (k == 1) ? 2 : 3;
          ek = (t == 2);
          hh[q] = HDR_W'((b << 8) | t);
          push(q);
          wait_any(seen);
          chk(seen, "R2 packet taken", int'(seen), 1);
          if (ek) begin
            chk(disp_valid && !side_valid && int'(disp_qid) == q && disp_hdr == hh[q],
                "R2 kernel on dispatch port", int'(disp_qid), q);
            step();
            chk(barrier_held[q] == 1'(b), "R4 flag after dispatch", int'(barrier_held[q]), b);
            cmpl(q, fr, fq);
            chk(fr && fq == q, "R8 free on completion", int'(fr), 1);
            chk(!barrier_held[q], b ? "R6 flag cleared" : "R7 flag stays clear",
                int'(barrier_held[q]), 0);
          end else begin
            chk(side_valid && !disp_valid && int'(side_qid) == q, "R3 side route",
                int'(side_qid), q);
            step();
            chk(!side_valid && !barrier_held[q], "R3 one cycle, no flag",
                int'(barrier_held[q]), 0);
          end
          hh[q] = 16'h0002;
        end

    // R10 R11 round robin and hold
    disp_ready = 1'b0;
    push(1); push(2); push(3);
    repeat (6) step();
    chk(disp_valid && disp_qid == 2'd1, "R10 first from pointer", int'(disp_qid), 1);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(disp_valid && disp_qid == 2'd1, "R11 offer held", int'(disp_qid), 1);
    end
    disp_ready = 1'b1;
    for (int e = 1; e <= 3; e++) begin
      chk(disp_valid && int'(disp_qid) == e, "R10 rotation order", int'(disp_qid), e);
      step();
    end
    chk(!disp_valid, "R10 one per cycle, queue drained", int'(disp_valid), 0);

    // R8 free only when outstanding
    cmpl(3, fr, fq);
    chk(fr && fq == 3, "R8 free with outstanding", int'(fr), 1);
    cmpl(3, fr, fq);
    chk(!fr, "R8 no free without outstanding", int'(fr), 0);
    cmpl(1, fr, fq);
    cmpl(2, fr, fq);

    // R5 R6 blocking and release
    hh[0] = 16'h0102;
    push(0);
    wait_any(seen);
    chk(disp_valid && disp_qid == 2'd0, "R4 barrier kernel offered", int'(disp_qid), 0);
    step();
    chk(barrier_held[0], "R4 flag raised", int'(barrier_held[0]), 1);
    push(0);
    push(2);
    bad = 1'b0; saw2 = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (disp_valid && disp_qid == 2'd0) bad = 1'b1;
      if (disp_valid && disp_qid == 2'd2) saw2 = 1'b1;
      step();
    end
    chk(!bad, "R5 held queue not offered", int'(bad), 0);
    chk(saw2, "R5 other queue served", int'(saw2), 1);
    chk(barrier_held[0], "R5 flag still set", int'(barrier_held[0]), 1);
    cmpl(0, fr, fq);
    chk(!barrier_held[0], "R6 flag cleared", int'(barrier_held[0]), 0);
    wait_any(seen);
    chk(seen && disp_valid && disp_qid == 2'd0, "R6 pending resumed", int'(disp_qid), 0);
    step();
    chk(barrier_held[0], "R4 flag raised again", int'(barrier_held[0]), 1);
    cmpl(0, fr, fq);
    chk(!barrier_held[0], "R6 cleared with nothing pending", int'(barrier_held[0]), 0);
    bad = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (disp_valid || side_valid) bad = 1'b1;
      step();
    end
    chk(!bad, "R6 nothing offered without work", int'(bad), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule